// File: doc/BRIEF.md
# Wait-State Memory Responder

This block is a word-wide memory target meant to sit on the far side of a cache's refill and write-back port. Each access it accepts keeps it busy for a fixed number of cycles before it reports ready again. The timing is deliberately slow and very regular, so it can stand in for an off-chip memory in a test system. A requester raises the select line together with the write flag, a byte address and write data. It then waits until the ready flag comes back. At that point the read data for the accepted address is on the output.

Inside, a small wrap-around counter sets the busy window. The request is registered at the moment of acceptance. A write lands in the storage array only in the final busy cycle, and it is taken from the registered copy. The array is indexed by word address, uses only as many address bits as its depth needs, and starts up with a computed pattern so that reads return known data before anything has been written.

Top module: `wait_mem_responder`

## Requirements
- R1: `rsp_ready` is high whenever no access is outstanding. It stays high through idle cycles, and it is high immediately after reset.
- R2: An access is accepted on a rising edge where `req_en` and `rsp_ready` are both high. `rsp_ready` is then low after that edge and after the next two edges, and it is high again after the fourth edge counted from acceptance.
- R3: A `req_en` raised while `rsp_ready` is low is ignored. Its address, write flag and data are not captured and nothing is written to the array.
- R4: An accepted write changes the array word in the last busy cycle, using the registered address and data. A read of that word afterwards returns the written value.
- R5: When `rsp_ready` is high, `rsp_rdata` shows the array word at the most recently accepted address. It keeps showing that word through idle cycles until the next acceptance.
- R6: Only the word-index bits `req_addr[IDX_W+1:2]` select a word, with IDX_W = log2(DEPTH) (12 at the default depth of 4096). The two low address bits are ignored, and addresses that differ only above the index bits reach the same word.
- R7: While `rsp_ready` is low, `rsp_rdata` is all zeros.
- R8: Before any write, the word at index i holds `(i * 32'h9E3779B1) ^ SEED`.
- R9: The asynchronous active-low `rst_n` clears the busy count and the registered request, including its address (0) and write flag. A write whose busy window is cut by reset never reaches the array. After reset, `rsp_rdata` shows word 0.
- R10: If `req_en` is held high continuously, a new access is accepted on the edge where ready has just returned. Each access still takes the full four-cycle window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_en | input | 1 | Access request (select), active high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data; valid while ready is high, zero while busy |
| rsp_ready | output | 1 | High when idle and able to accept |

## Verification
The hardest situation to reach from the ports is a write request that arrives in the middle of another access's busy window and is aimed at a different word. A correct design drops it silently. The only way to show that it was dropped is to read that word back later and compare it with the value it had before. The stimulus holds a write request high through the first busy cycles of a genuine write, lowers it before ready returns, and then reads both the genuine target and the decoy target. A second hard case is a reset that lands while a write is still pending. It is reached by pulsing reset one cycle after the write is accepted, and the word is read afterwards to confirm that the write was lost.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  localparam logic [31:0] GOLDEN = 32'h9E3779B1;

  // Preload pattern for word index i
  function automatic logic [31:0] init_word(input int unsigned i, input logic [31:0] seed);
    return (32'(i) * GOLDEN) ^ seed;
  endfunction

  // Word number from a byte address
  function automatic logic [31:0] word_of(input logic [31:0] byte_addr);
    return byte_addr >> 2;
  endfunction
endpackage

// File: rtl/wsm_busy_ctr.sv
module wsm_busy_ctr #(
  parameter int BUSY_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_en,
  output logic ready,
  output logic last_busy
);
  localparam logic [BUSY_W-1:0] LAST = '1;

  logic [BUSY_W-1:0] cnt;
  logic              advance;

  assign advance   = req_en || (cnt != '0);
  assign ready     = (cnt == '0);
  assign last_busy = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (advance) cnt <= cnt + BUSY_W'(1);
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && ready) |=> !ready);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req_en) |=> ready);
endmodule

// File: rtl/wsm_req_capture.sv
module wsm_req_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));
endmodule

// File: rtl/wsm_store.sv
module wsm_store #(
  parameter int          DATA_W = 32,
  parameter int          DEPTH  = 4096,
  parameter logic [31:0] SEED   = 32'h5A5A0F0F,
  localparam int         IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              commit,
  input  logic              show,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(wsm_pkg::init_word(i, SEED));
  end

  always_ff @(posedge clk) begin
    if (commit) mem[idx] <= wdata;
  end

  assign rdata = show ? mem[idx] : '0;
endmodule

// File: rtl/wait_mem_responder.sv
module wait_mem_responder #(
  parameter int          DEPTH  = 4096,
  parameter int          BUSY_W = 2,
  parameter logic [31:0] SEED   = 32'h5A5A0F0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_en,
  input  logic        req_wr,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        rsp_ready
);
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              last_busy;
  logic              take_evt;
  logic              commit_evt;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [31:0]       word_q;
  logic [IDX_W-1:0]  idx_q;

  wsm_busy_ctr #(.BUSY_W(BUSY_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .req_en(req_en),
    .ready(rsp_ready), .last_busy(last_busy)
  );

  assign take_evt = req_en && rsp_ready;

  wsm_req_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take_evt), .ready(rsp_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  assign word_q     = wsm_pkg::word_of(addr_q);
  assign idx_q      = word_q[IDX_W-1:0];
  assign commit_evt = wr_q && last_busy;

  wsm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEED(SEED)) u_mem (
    .clk(clk), .commit(commit_evt), .show(rsp_ready),
    .idx(idx_q), .wdata(wdata_q), .rdata(rsp_rdata)
  );

  // R7
  busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> (rsp_rdata == '0));
  // R4
  commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (rsp_ready && rsp_rdata == $past(wdata_q)));
  // R2
  commit_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_busy |=> rsp_ready);
endmodule

// File: tb/sim_wait_mem_responder.sv
module sim_wait_mem_responder;
  localparam int          DEPTH = 4096;
  localparam logic [31:0] SEED  = 32'h5A5A0F0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_en = 1'b0, req_wr = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic rsp_ready;

  always #2 clk = ~clk;

  wait_mem_responder #(.DEPTH(DEPTH), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready)
  );

  typedef struct { bit is_rd; logic [31:0] exp; } item_t;
  item_t q[$];
  logic [31:0] ref_mem [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit prev_rdy = 1'b1;
  bit done = 1'b0;

  function automatic int ix(input logic [31:0] a);
    return int'((a / 4) % DEPTH);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard consumer
  always @(negedge clk) begin
    if (!rst_n) prev_rdy = 1'b1;
    else begin
      if (!rsp_ready) chk(rsp_rdata == 32'h0, "R7 busy data", rsp_rdata, 32'h0);
      if (rsp_ready && !prev_rdy) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected ready", 32'd0, 32'd1);
        else begin
          item_t it;
          it = q.pop_front();
          if (it.is_rd) chk(rsp_rdata == it.exp, "R5 read data", rsp_rdata, it.exp);
        end
      end
      prev_rdy = rsp_ready;
    end
  end

  // Driver: one access, optional decoy write held during the busy window
  task automatic acc(input bit wr, input logic [31:0] a, input logic [31:0] d,
                     input bit noise, input logic [31:0] na, input logic [31:0] nd);
    item_t it;
    @(negedge clk);
    req_en = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    it.is_rd = !wr; it.exp = ref_mem[ix(a)];
    q.push_back(it);
    if (wr) ref_mem[ix(a)] = d;
    @(negedge clk);
    chk(rsp_ready == 1'b0, "R2 busy 1", 32'(rsp_ready), 32'd0);
    if (noise) begin req_wr = 1'b1; req_addr = na; req_wdata = nd; end
    else req_en = 1'b0;
    @(negedge clk);
    chk(rsp_ready == 1'b0, "R2 busy 2", 32'(rsp_ready), 32'd0);
    @(negedge clk);
    chk(rsp_ready == 1'b0, "R2 busy 3", 32'(rsp_ready), 32'd0);
    req_en = 1'b0;
    @(negedge clk);
    chk(rsp_ready == 1'b1, "R2 ready back", 32'(rsp_ready), 32'd1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = SEED ^ (32'(i) * 32'd2654435761);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9 R8: reset state
    chk(rsp_ready == 1'b1, "R1 ready after reset", 32'(rsp_ready), 32'd1);
    chk(rsp_rdata == ref_mem[0], "R9 R8 word 0 after reset", rsp_rdata, ref_mem[0]);

    // R8 R5: preload reads
    acc(1'b0, 32'h0000_0010, 32'h0, 1'b0, 32'h0, 32'h0);
    acc(1'b0, 32'h0000_3FFC, 32'h0, 1'b0, 32'h0, 32'h0);
    acc(1'b0, 32'h0000_0124, 32'h0, 1'b0, 32'h0, 32'h0);

    // R4: write then read
    acc(1'b1, 32'h0000_0200, 32'hDEADBEEF, 1'b0, 32'h0, 32'h0);
    acc(1'b0, 32'h0000_0200, 32'h0, 1'b0, 32'h0, 32'h0);

    // R6: low bits ignored and high-bit aliasing
    acc(1'b1, 32'h0000_0301, 32'h1234_5678, 1'b0, 32'h0, 32'h0);
    acc(1'b0, 32'h0000_0303, 32'h0, 1'b0, 32'h0, 32'h0);
    acc(1'b0, 32'h0000_4200, 32'h0, 1'b0, 32'h0, 32'h0);
    chk(rsp_rdata == 32'hDEADBEEF, "R6 alias word", rsp_rdata, 32'hDEADBEEF);

    // R3: decoy write during busy window is ignored
    acc(1'b1, 32'h0000_0500, 32'h1111_1111, 1'b1, 32'h0000_0600, 32'h0BAD_0BAD);
    acc(1'b0, 32'h0000_0600, 32'h0, 1'b0, 32'h0, 32'h0);
    chk(rsp_rdata == ref_mem[ix(32'h600)], "R3 decoy not written", rsp_rdata, ref_mem[ix(32'h600)]);
    acc(1'b0, 32'h0000_0500, 32'h0, 1'b0, 32'h0, 32'h0);

    // R5: data held through idle cycles
    repeat (5) @(negedge clk);
    chk(rsp_rdata == 32'h1111_1111, "R5 hold while idle", rsp_rdata, 32'h1111_1111);
    chk(rsp_ready == 1'b1, "R1 idle ready", 32'(rsp_ready), 32'd1);

    // R9: reset cuts a pending write
    @(negedge clk);
    req_en = 1'b1; req_wr = 1'b1; req_addr = 32'h0000_0700; req_wdata = 32'h0000_CAFE;
    @(negedge clk);
    req_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_ready == 1'b1, "R9 ready after mid reset", 32'(rsp_ready), 32'd1);
    chk(rsp_rdata == ref_mem[0], "R9 address cleared", rsp_rdata, ref_mem[0]);
    repeat (4) @(negedge clk);
    acc(1'b0, 32'h0000_0700, 32'h0, 1'b0, 32'h0, 32'h0);
    chk(rsp_rdata == ref_mem[ix(32'h700)], "R9 write discarded", rsp_rdata, ref_mem[ix(32'h700)]);

    // R10: select held continuously
    begin
      item_t a1, a2;
      @(negedge clk);
      req_en = 1'b1; req_wr = 1'b0; req_addr = 32'h0000_0010;
      a1.is_rd = 1'b1; a1.exp = ref_mem[ix(32'h10)]; q.push_back(a1);
      @(negedge clk);
      req_addr = 32'h0000_0200;
      a2.is_rd = 1'b1; a2.exp = ref_mem[ix(32'h200)]; q.push_back(a2);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(rsp_ready == 1'b1, "R10 ready between", 32'(rsp_ready), 32'd1);
      @(negedge clk);
      chk(rsp_ready == 1'b0, "R10 reaccepted", 32'(rsp_ready), 32'd0);
      req_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(rsp_ready == 1'b1, "R10 second window", 32'(rsp_ready), 32'd1);
      chk(rsp_rdata == 32'hDEADBEEF, "R10 second data", rsp_rdata, 32'hDEADBEEF);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all accesses completed", 32'(q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule